// File: doc/BRIEF.md
# Floppy Controller Command/Result Sequencer

This block is the host-facing phase engine of a floppy disk controller. The host sees a status byte and one byte-wide data port. It writes an opcode and its parameter bytes through the port. The controller then runs an execution phase. Execution is modelled by a fixed delay and by a stub that generates sector bytes. Last, the controller hands back result bytes through the same port. The status byte tells the host whether the port is ready, which way data flows, whether a command is in progress, and whether sector data is moving by programmed I/O.

Three opcodes are decoded: sector read (0xE6), verify (0x16) and read-identifier (0x0A). Any other opcode produces an invalid-command result. A sector read with media present and the DMA-enable input low gives a programmed-I/O data phase. The host pulls every byte of every sector from the start sector up to the end-of-track sector. The interrupt marks the end of execution. It is withdrawn when the host takes the final result byte.

Top module: `fdc_phase_seq`

## Requirements
- R1: After reset the status byte is 0x80 and the interrupt is low.
- R2: The port accepts a written byte only while status bit 7 is set and bit 6 is clear. A write during execution or during the result phase has no effect on the status byte or on the result bytes returned.
- R3: Read and verify take 8 parameter bytes after the opcode, and read-identifier takes 1. The status byte is 0x90 while parameters are pending and 0x10 during execution.
- R4: The interrupt stays low while parameters are accepted, during execution and during the data phase. It rises in the same cycle that the result phase (status 0xD0) begins for read, verify and read-identifier.
- R5: A read with media present and DMA-enable low shows status 0xF0 in the data phase. The data phase delivers SECTOR_BYTES bytes for each sector from the start sector (parameter 4) to the end-of-track sector (parameter 6). If the end-of-track sector is below the start sector, exactly one sector is delivered. Byte i of sector s equals (i mod 256) XOR s.
- R6: Read and verify return 7 result bytes, in this order: ST0, 0, 0, cylinder (parameter 2), head (parameter 3), end-of-track sector, size code (parameter 5). ST0 = 0x40 when no media is present, OR head-select bit (parameter 1 bit 2) << 2, OR drive (parameter 1 bits 1:0). The interrupt stays high through the first six bytes. After the seventh byte the status byte is 0x80 and the interrupt is low.
- R7: A read without media has no data phase. The status byte goes straight from 0x10 to 0xD0, and ST0 has bit 6 set.
- R8: DMA-enable is sampled when the last parameter byte is written. If it is high then, the read skips the data phase. A change to DMA-enable during execution has no effect on that command.
- R9: Verify never has a data phase.
- R10: Read-identifier returns ST0, 0, 0, the track register, the head-select bit, 1, 2. The track register is 0 after reset and takes the cylinder parameter of each executed read or verify.
- R11: Any opcode other than 0xE6, 0x16 or 0x0A gives a single result byte 0x80 with status 0xD0 and no interrupt. The status byte returns to 0x80 after that byte is read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataWrEn | input | 1 | Host write strobe for the data port |
| dataWrByte | input | 8 | Byte written by the host |
| dataRdEn | input | 1 | Host read strobe; the byte shown is consumed at the clock edge |
| dataRdByte | output | 8 | Byte presented on the data port |
| msr | output | 8 | Status byte: bit 7 ready, bit 6 to host, bit 5 programmed I/O, bit 4 busy |
| dmaEnable | input | 1 | DMA-enable control bit; low selects programmed-I/O transfer |
| mediaPresent | input | 1 | Media present in the selected drive |
| irq | output | 1 | End-of-execution interrupt |

## Verification
A wrong phase register or a wrong parameter counter shows up at the very next host access. The status byte takes a value that differs from the expected 0x90/0x10/0xF0/0xD0 sequence, or a write is taken when it should be refused. Errors in the sector or byte counters show up in the data phase as a byte that does not match the index XOR sector pattern. They can also show up as a data phase one sector too long or too short, which is caught by the status byte after the final expected byte. A faulty result index or interrupt release is seen within seven reads: a wrong result byte, or an interrupt that drops before the seventh byte or stays high after it.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

  typedef enum logic [2:0] {
    PH_CMD, PH_PARAM, PH_EXEC, PH_DATA, PH_RES
  } phase_t;

  typedef enum logic [1:0] {
    K_READ, K_VERIFY, K_READID, K_INVALID
  } cmdKind_t;

  localparam logic [7:0] OP_READ   = 8'hE6;
  localparam logic [7:0] OP_VERIFY = 8'h16;
  localparam logic [7:0] OP_READID = 8'h0A;

  localparam logic [7:0] MSR_RQM  = 8'h80;
  localparam logic [7:0] MSR_DIO  = 8'h40;
  localparam logic [7:0] MSR_NDMA = 8'h20;
  localparam logic [7:0] MSR_BUSY = 8'h10;

  // control to datapath strobes
  typedef struct packed {
    logic       storeParam;
    logic [2:0] paramSlot;
    logic       startExec;
    logic       abnormal;
    logic       loadData;
    logic       stepData;
    logic       showData;
    logic [2:0] resSlot;
  } dpStrobe_t;

  function automatic cmdKind_t decodeOp(input logic [7:0] op);
    case (op)
      OP_READ:   return K_READ;
      OP_VERIFY: return K_VERIFY;
      OP_READID: return K_READID;
      default:   return K_INVALID;
    endcase
  endfunction

  function automatic logic [3:0] paramCount(input cmdKind_t k);
    case (k)
      K_READ, K_VERIFY: return 4'd8;
      K_READID:         return 4'd1;
      default:          return 4'd0;
    endcase
  endfunction

  function automatic logic [2:0] resultCount(input cmdKind_t k);
    return (k == K_INVALID) ? 3'd1 : 3'd7;
  endfunction

endpackage

// File: rtl/fdc_seq_ctrl.sv
module fdc_seq_ctrl
  import fdc_seq_pkg::*;
#(
  parameter int EXEC_DELAY = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      dataWrEn,
  input  logic [7:0] dataWrByte,
  input  logic      dataRdEn,
  input  logic      dmaEnable,
  input  logic      mediaPresent,
  input  logic      dataLast,
  output dpStrobe_t strb,
  output cmdKind_t  kind,
  output logic [7:0] msr,
  output logic      irq
);

  localparam int CW = $clog2(EXEC_DELAY + 1);

  phase_t        phase;
  logic [3:0]    paramIdx;
  logic [3:0]    paramTotal;
  logic [2:0]    resIdx;
  logic [2:0]    resTotal;
  logic [CW-1:0] execCnt;
  logic          useDma;
  logic          hasMedia;
  logic          irqQ;

  logic wrOk, rdOk, execDone, goData;
  cmdKind_t newKind;

  assign wrOk     = dataWrEn && (phase == PH_CMD || phase == PH_PARAM);
  assign rdOk     = dataRdEn && (phase == PH_DATA || phase == PH_RES);
  assign execDone = (phase == PH_EXEC) && (execCnt == '0);
  assign goData   = (kind == K_READ) && hasMedia && !useDma;
  assign newKind  = decodeOp(dataWrByte);

  always_comb begin
    strb            = '0;
    strb.storeParam = wrOk && (phase == PH_PARAM);
    strb.paramSlot  = paramIdx[2:0];
    strb.startExec  = strb.storeParam && (paramIdx == paramTotal - 4'd1);
    strb.abnormal   = !mediaPresent;
    strb.loadData   = execDone && goData;
    strb.stepData   = rdOk && (phase == PH_DATA);
    strb.showData   = (phase == PH_DATA);
    strb.resSlot    = resIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= PH_CMD;
      kind       <= K_INVALID;
      paramIdx   <= '0;
      paramTotal <= '0;
      resIdx     <= '0;
      resTotal   <= '0;
      execCnt    <= '0;
      useDma     <= 1'b0;
      hasMedia   <= 1'b0;
      irqQ       <= 1'b0;
    end else begin
      case (phase)
        PH_CMD: if (wrOk) begin
          kind       <= newKind;
          paramIdx   <= '0;
          paramTotal <= paramCount(newKind);
          resIdx     <= '0;
          resTotal   <= resultCount(newKind);
          phase      <= (newKind == K_INVALID) ? PH_RES : PH_PARAM;
        end
        PH_PARAM: if (wrOk) begin
          paramIdx <= paramIdx + 4'd1;
          if (strb.startExec) begin
            phase    <= PH_EXEC;
            execCnt  <= CW'(EXEC_DELAY - 1);
            useDma   <= dmaEnable;
            hasMedia <= mediaPresent;
          end
        end
        PH_EXEC: begin
          if (execDone) begin
            if (goData) phase <= PH_DATA;
            else begin
              phase <= PH_RES;
              irqQ  <= 1'b1;
            end
          end else begin
            execCnt <= execCnt - CW'(1);
          end
        end
        PH_DATA: if (rdOk && dataLast) begin
          phase <= PH_RES;
          irqQ  <= 1'b1;
        end
        PH_RES: if (rdOk) begin
          if (resIdx == resTotal - 3'd1) begin
            phase <= PH_CMD;
            irqQ  <= 1'b0;
          end else begin
            resIdx <= resIdx + 3'd1;
          end
        end
        default: phase <= PH_CMD;
      endcase
    end
  end

  always_comb begin
    case (phase)
      PH_CMD:   msr = MSR_RQM;
      PH_PARAM: msr = MSR_RQM | MSR_BUSY;
      PH_EXEC:  msr = MSR_BUSY;
      PH_DATA:  msr = MSR_RQM | MSR_DIO | MSR_NDMA | MSR_BUSY;
      PH_RES:   msr = MSR_RQM | MSR_DIO | MSR_BUSY;
      default:  msr = MSR_RQM;
    endcase
  end

  assign irq = irqQ;

endmodule

// File: rtl/fdc_seq_dp.sv
module fdc_seq_dp
  import fdc_seq_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] dataWrByte,
  input  dpStrobe_t  strb,
  input  cmdKind_t   kind,
  output logic       dataLast,
  output logic [7:0] rdByte
);

  localparam int BW = $clog2(SECTOR_BYTES);
  localparam int NPARAM = 8;
  // parameter slot meaning
  localparam int S_SEL = 0, S_CYL = 1, S_HEAD = 2, S_SEC = 3, S_SIZE = 4, S_EOT = 5;

  logic [7:0]    prm [NPARAM];
  logic [7:0]    track;
  logic          abn;
  logic [7:0]    sectorNum;
  logic [BW-1:0] byteIdx;
  logic          lastByte;
  logic [7:0]    st0;
  logic [7:0]    resByte;

  genvar g;
  generate
    for (g = 0; g < NPARAM; g++) begin : gSlot
      always_ff @(posedge clk) begin
        if (!rstN) prm[g] <= '0;
        else if (strb.storeParam && strb.paramSlot == 3'(g)) prm[g] <= dataWrByte;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      track <= '0;
      abn   <= 1'b0;
    end else if (strb.startExec) begin
      abn <= strb.abnormal;
      if (kind == K_READ || kind == K_VERIFY) track <= prm[S_CYL];
    end
  end

  assign lastByte = (byteIdx == BW'(SECTOR_BYTES - 1));
  assign dataLast = lastByte && (sectorNum >= prm[S_EOT]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sectorNum <= '0;
      byteIdx   <= '0;
    end else if (strb.loadData) begin
      sectorNum <= prm[S_SEC];
      byteIdx   <= '0;
    end else if (strb.stepData) begin
      if (lastByte) begin
        byteIdx   <= '0;
        sectorNum <= sectorNum + 8'd1;
      end else begin
        byteIdx <= byteIdx + BW'(1);
      end
    end
  end

  assign st0 = {1'b0, abn, 3'b000, prm[S_SEL][2], prm[S_SEL][1:0]};

  always_comb begin
    resByte = 8'h00;
    if (kind == K_INVALID) begin
      resByte = 8'h80;
    end else begin
      case (strb.resSlot)
        3'd0: resByte = st0;
        3'd3: resByte = (kind == K_READID) ? track : prm[S_CYL];
        3'd4: resByte = (kind == K_READID) ? {7'd0, prm[S_SEL][2]} : prm[S_HEAD];
        3'd5: resByte = (kind == K_READID) ? 8'h01 : prm[S_EOT];
        3'd6: resByte = (kind == K_READID) ? 8'h02 : prm[S_SIZE];
        default: resByte = 8'h00;
      endcase
    end
  end

  assign rdByte = strb.showData ? (8'(byteIdx) ^ sectorNum) : resByte;

endmodule

// File: rtl/fdc_phase_seq.sv
module fdc_phase_seq
  import fdc_seq_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int EXEC_DELAY   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dataWrEn,
  input  logic [7:0] dataWrByte,
  input  logic       dataRdEn,
  output logic [7:0] dataRdByte,
  output logic [7:0] msr,
  input  logic       dmaEnable,
  input  logic       mediaPresent,
  output logic       irq
);

  dpStrobe_t strb;
  cmdKind_t  kind;
  logic      dataLast;

  fdc_seq_ctrl #(.EXEC_DELAY(EXEC_DELAY)) uCtrl (
    .clk(clk), .rstN(rstN), .dataWrEn(dataWrEn), .dataWrByte(dataWrByte),
    .dataRdEn(dataRdEn), .dmaEnable(dmaEnable), .mediaPresent(mediaPresent),
    .dataLast(dataLast), .strb(strb), .kind(kind), .msr(msr), .irq(irq)
  );

  fdc_seq_dp #(.SECTOR_BYTES(SECTOR_BYTES)) uDp (
    .clk(clk), .rstN(rstN), .dataWrByte(dataWrByte), .strb(strb),
    .kind(kind), .dataLast(dataLast), .rdByte(dataRdByte)
  );

endmodule

// File: rtl/fdc_phase_seq_chk.sv
module fdc_phase_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       dataWrEn,
  input logic       dataRdEn,
  input logic [7:0] dataRdByte,
  input logic [7:0] msr,
  input logic       irq
);

  AST_MSR_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (msr == 8'h80 || msr == 8'h90 || msr == 8'h10 || msr == 8'hF0 || msr == 8'hD0)); // R3

  AST_IRQ_QUIET_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    (msr == 8'h90 || msr == 8'h10 || msr == 8'hF0) |-> !irq); // R4

  AST_IRQ_RISE_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> msr == 8'hD0); // R4

  AST_IRQ_FALL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> msr == 8'h80); // R6

  AST_RESULT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (msr == 8'hD0 && dataWrEn && !dataRdEn) |=> (msr == 8'hD0 && $stable(dataRdByte))); // R2

endmodule

bind fdc_phase_seq fdc_phase_seq_chk uChk (
  .clk(clk), .rstN(rstN), .dataWrEn(dataWrEn), .dataRdEn(dataRdEn),
  .dataRdByte(dataRdByte), .msr(msr), .irq(irq)
);

// File: tb/fdc_phase_seq_test.sv
module fdc_phase_seq_test;

  localparam int SB = 16;
  localparam int ED = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dataWrEn = 1'b0;
  logic [7:0] dataWrByte = 8'h00;
  logic       dataRdEn = 1'b0;
  logic [7:0] dataRdByte;
  logic [7:0] msr;
  logic       dmaEnable = 1'b0;
  logic       mediaPresent = 1'b1;
  logic       irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] expTrack = 8'h00;

  always #10 clk = ~clk;

  fdc_phase_seq #(.SECTOR_BYTES(SB), .EXEC_DELAY(ED)) uut (
    .clk(clk), .rstN(rstN), .dataWrEn(dataWrEn), .dataWrByte(dataWrByte),
    .dataRdEn(dataRdEn), .dataRdByte(dataRdByte), .msr(msr),
    .dmaEnable(dmaEnable), .mediaPresent(mediaPresent), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    chk(msr[7] && !msr[6], "R2 write allowed", msr, 8'h80);
    dataWrByte = b;
    dataWrEn = 1'b1;
    @(negedge clk);
    dataWrEn = 1'b0;
  endtask

  task automatic pokeByte(input logic [7:0] b);
    @(negedge clk);
    dataWrByte = b;
    dataWrEn = 1'b1;
    @(negedge clk);
    dataWrEn = 1'b0;
  endtask

  task automatic recvByte(output logic [7:0] b);
    @(negedge clk);
    b = dataRdByte;
    dataRdEn = 1'b1;
    @(negedge clk);
    dataRdEn = 1'b0;
  endtask

  task automatic waitLeaveExec();
    for (int i = 0; i < 40 && msr == 8'h10; i++) @(negedge clk);
  endtask

  // issue a read or verify and check every phase
  task automatic runXfer(input logic [7:0] op, input logic [1:0] drv, input logic hd,
                         input logic [7:0] cyl, input logic [7:0] sec, input logic [7:0] eot,
                         input logic [7:0] size, input logic media, input logic dmaStart,
                         input logic pokeExec);
    logic [7:0] b;
    logic [7:0] res [7];
    logic [7:0] lastSec;
    bit expData;
    mediaPresent = media;
    dmaEnable = dmaStart;
    expData = (op == 8'hE6) && media && !dmaStart;
    sendByte(op);
    chk(msr == 8'h90, "R3 param phase", msr, 8'h90);
    sendByte({5'd0, hd, drv});
    chk(!irq, "R4 no irq in params", irq, 0);
    sendByte(cyl); sendByte({7'd0, hd}); sendByte(sec); sendByte(size);
    sendByte(eot); sendByte(8'h1B);
    chk(msr == 8'h90, "R3 eight params pending", msr, 8'h90);
    sendByte(8'hFF);
    chk(msr == 8'h10 && !irq, "R3 exec status", msr, 8'h10);
    dmaEnable = !dmaStart;   // R8 late change ignored
    if (pokeExec) pokeByte(8'h5A);
    waitLeaveExec();
    dmaEnable = dmaStart;
    expTrack = cyl;
    if (expData) begin
      chk(msr == 8'hF0 && !irq, "R5 data status", msr, 8'hF0);
      lastSec = (eot >= sec) ? eot : sec;
      for (int s = sec; s <= lastSec; s++) begin
        for (int i = 0; i < SB; i++) begin
          recvByte(b);
          chk(b == (8'(i) ^ 8'(s)), "R5 data byte", b, 8'(i) ^ 8'(s));
        end
      end
    end else begin
      chk(msr == 8'hD0, (op == 8'h16) ? "R9 verify no data" :
          (!media ? "R7 no media result" : "R8 dma skips data"), msr, 8'hD0);
    end
    @(negedge clk);
    chk(msr == 8'hD0 && irq, "R4 result with irq", {irq, msr}, 9'h1D0);
    res[0] = (media ? 8'h00 : 8'h40) | {5'd0, hd, drv};
    res[1] = 8'h00; res[2] = 8'h00; res[3] = cyl; res[4] = {7'd0, hd};
    res[5] = eot; res[6] = size;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      chk(irq, "R6 irq held", irq, 1);
      if (k == 2) begin
        pokeByte(8'hA5);
        chk(msr == 8'hD0, "R2 write ignored in results", msr, 8'hD0);
      end
      recvByte(b);
      chk(b == res[k], (k == 0 && !media) ? "R7 st0 abnormal" : "R6 result byte", b, res[k]);
    end
    chk(msr == 8'h80 && !irq, "R6 back to command", {irq, msr}, 9'h080);
  endtask

  task automatic runReadId(input logic [1:0] drv, input logic hd);
    logic [7:0] b;
    logic [7:0] res [7];
    mediaPresent = 1'b1;
    sendByte(8'h0A);
    chk(msr == 8'h90 && !irq, "R3 readid param", msr, 8'h90);
    sendByte({5'd0, hd, drv});
    chk(msr == 8'h10, "R10 readid exec", msr, 8'h10);
    waitLeaveExec();
    chk(msr == 8'hD0 && irq, "R10 readid result", {irq, msr}, 9'h1D0);
    res[0] = {5'd0, hd, drv}; res[1] = 0; res[2] = 0; res[3] = expTrack;
    res[4] = {7'd0, hd}; res[5] = 8'h01; res[6] = 8'h02;
    for (int k = 0; k < 7; k++) begin
      recvByte(b);
      chk(b == res[k], "R10 readid byte", b, res[k]);
    end
    chk(msr == 8'h80 && !irq, "R10 readid done", {irq, msr}, 9'h080);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(msr == 8'h80 && !irq, "R1 reset state", {irq, msr}, 9'h080);
    runReadId(2'd0, 1'b0);   // R10 track zero after reset

    // R5 sweep over start and end sectors, heads and cylinders
    for (int c = 0; c < 2; c++)
      for (int h = 0; h < 2; h++)
        for (int s = 1; s <= 3; s++)
          for (int e = s - 1; e <= 3; e++)
            runXfer(8'hE6, 2'(c + h), 1'(h), 8'(c * 7 + 2), 8'(s), 8'(e), 8'd2,
                    1'b1, 1'b0, 1'b0);

    runReadId(2'd1, 1'b1);   // R10 track from last read
    runXfer(8'hE6, 2'd0, 1'b0, 8'd0, 8'd1, 8'd1, 8'd2, 1'b0, 1'b0, 1'b0); // R7
    runXfer(8'hE6, 2'd2, 1'b1, 8'd9, 8'd1, 8'd2, 8'd2, 1'b1, 1'b1, 1'b1); // R8
    runXfer(8'hE6, 2'd0, 1'b0, 8'd4, 8'd1, 8'd2, 8'd2, 1'b1, 1'b0, 1'b1); // R8 late
    runXfer(8'h16, 2'd3, 1'b1, 8'd12, 8'd1, 8'd5, 8'd3, 1'b1, 1'b0, 1'b1); // R9
    runReadId(2'd3, 1'b0);

    // R11 undecoded opcodes
    for (int op = 0; op < 256; op += 37) begin
      if (op == 8'hE6 || op == 8'h16 || op == 8'h0A) continue;
      sendByte(8'(op));
      @(negedge clk);
      chk(msr == 8'hD0 && !irq, "R11 invalid result phase", {irq, msr}, 9'h0D0);
      recvByte(b);
      chk(b == 8'h80, "R11 invalid st0", b, 8'h80);
      chk(msr == 8'h80 && !irq, "R11 back to command", {irq, msr}, 9'h080);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule